// File: doc/BRIEF.md
# Tree-Structured Binary Magnitude Comparator

This block compares two unsigned operands of a parameterised width and reports whether the first is less than, equal to, or greater than the second. It has no clock and holds no state. The outputs follow the operands through combinational logic only.

The result comes from a logarithmic tree shaped like carry-lookahead logic. Each bit is first encoded into a "smaller here" flag and a "same here" flag. A leaf cell then turns each 2-bit slice into a span result, which is a pair of signals (B bigger, equal). Merge cells join neighbouring spans level by level. The upper span's "B bigger" acts as a generate term, its "equal" acts as a propagate term, and the lower span's "B bigger" acts as the carry-in. Odd merge levels produce complemented pairs and even merge levels restore true polarity, so that no level has to add an inverter. A final inversion is placed only when the number of merge levels is odd.

The greater-than output is never computed in the tree. It is the case where neither of the other two outputs is raised.

Top module: `mag_cmp_tree`

## Requirements
- R1: `lt_o` is high exactly when `opa` is less than `opb`, both taken as unsigned numbers.
- R2: `eq_o` is high exactly when `opa` and `opb` are bit-for-bit identical.
- R3: `gt_o` is high exactly when `opa` is greater than `opb`. It is the case where both `lt_o` and `eq_o` are low.
- R4: Exactly one of `lt_o`, `eq_o`, `gt_o` is high for every operand pair. Every internal span result is one of three legal pairs: (1,0) less, (0,1) equal, (0,0) greater. The pair (1,1) never appears in true polarity.
- R5: When the operands differ only in the most significant bit, that bit alone decides the result. A 1 in `opa` gives greater and a 1 in `opb` gives less.
- R6: When the operands differ only in bit 0, that bit decides the result in the same way.
- R7: All-zeros against all-ones gives less. All-ones against all-zeros gives greater.
- R8: The highest differing bit decides the result, whatever the values of the bits below it.
- R9: `WIDTH` must be a power of two and at least 2. The block must be correct for both an even and an odd number of merge levels, and also for the leaf-only case (`WIDTH` = 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| lt_o | output | 1 | opa is smaller than opb |
| eq_o | output | 1 | opa equals opb |
| gt_o | output | 1 | opa is larger than opb |

## Verification
The embedded checks watch the legal-pair rule at every merge cell's inputs on every evaluation. They also check the one-hot property of the three outputs, and they check that the equal and less outputs agree with a direct comparison of the operands. The leaf cells check that a raised equal flag means the slice really matches. Only the bench scenarios can show the rest. MSB-only and LSB-only differences and the all-zeros against all-ones extremes confirm that significance is ordered correctly. Differences at a random bit with noise below it confirm that the upper spans override the lower ones. Exhaustive sweeps at 2-bit and 8-bit widths show that the polarity bookkeeping is right when the merge-level count is zero or even, and the 64-bit runs cover the odd case.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

  // per-bit encodings: "b larger at this bit" and "bits match"
  function automatic logic bit_smaller(input logic a, input logic b);
    return ~a & b;
  endfunction

  function automatic logic bit_same(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

  // join an upper span (generate/propagate) with a lower span (carry-in)
  // returns {b_bigger, equal} in true polarity
  function automatic logic [1:0] span_join(input logic hi_big, input logic hi_eq,
                                           input logic lo_big, input logic lo_eq);
    return {hi_big | (hi_eq & lo_big), hi_eq & lo_eq};
  endfunction

  // first node index of tree level k inside the flattened node vector
  function automatic int level_base(input int width, input int k);
    return width - (width >> k);
  endfunction

endpackage

// File: rtl/cmpt_leaf.sv
module cmpt_leaf
  import cmpt_pkg::*;
(
  input  logic [1:0] sa,
  input  logic [1:0] sb,
  output logic       big,
  output logic       same
);
  logic [1:0] lt_bit;
  logic [1:0] eq_bit;

  for (genvar i = 0; i < 2; i++) begin : g_enc
    assign lt_bit[i] = bit_smaller(sa[i], sb[i]);
    assign eq_bit[i] = bit_same(sa[i], sb[i]);
  end

  assign {big, same} = span_join(lt_bit[1], eq_bit[1], lt_bit[0], 1'b0) | {1'b0, eq_bit[0] & eq_bit[1]};

  always_comb begin : chk
    // R2
    leaf_eq_chk: assert (!same || (sa == sb))
      else $error("leaf reports equal on differing slice");
  end
endmodule

// File: rtl/cmpt_merge_inv.sv
module cmpt_merge_inv
  import cmpt_pkg::*;
(
  input  logic hi_big,
  input  logic hi_eq,
  input  logic lo_big,
  input  logic lo_eq,
  output logic big_n,
  output logic eq_n
);
  logic [1:0] joined;

  assign joined = span_join(hi_big, hi_eq, lo_big, lo_eq);
  assign big_n  = ~joined[1];
  assign eq_n   = ~joined[0];

  always_comb begin : chk
    // R4
    pair_in_true_chk: assert (!(hi_big && hi_eq) && !(lo_big && lo_eq))
      else $error("illegal span pair into inverting merge");
  end
endmodule

// File: rtl/cmpt_merge_pos.sv
module cmpt_merge_pos (
  input  logic hi_big_n,
  input  logic hi_eq_n,
  input  logic lo_big_n,
  input  logic lo_eq_n,
  output logic big,
  output logic same
);
  // complemented inputs: nand/nor form restores true polarity
  assign big  = ~(hi_big_n & (hi_eq_n | lo_big_n));
  assign same = ~(hi_eq_n | lo_eq_n);

  always_comb begin : chk
    // R4
    pair_in_inv_chk: assert ((hi_big_n || hi_eq_n) && (lo_big_n || lo_eq_n))
      else $error("illegal complemented span pair into restoring merge");
  end
endmodule

// File: rtl/mag_cmp_tree.sv
module mag_cmp_tree
  import cmpt_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o
);
  localparam int LEVELS = $clog2(WIDTH);
  localparam int LEAVES = WIDTH / 2;
  localparam int NODES  = WIDTH - 1;
  localparam int MERGES = LEVELS - 1;
  localparam bit FLIP   = (MERGES % 2) == 1;

  // R9
  if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
    $error("WIDTH must be a power of two, at least 2");
  end

  // flattened tree: level k occupies [level_base(k) +: WIDTH>>(k+1)]
  logic [NODES-1:0] nd_big;
  logic [NODES-1:0] nd_eq;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    cmpt_leaf u_leaf (
      .sa   (opa[2*j+1 -: 2]),
      .sb   (opb[2*j+1 -: 2]),
      .big  (nd_big[j]),
      .same (nd_eq[j])
    );
  end

  for (genvar k = 1; k < LEVELS; k++) begin : g_lvl
    localparam int NG  = WIDTH >> (k + 1);
    localparam int SRC = level_base(WIDTH, k - 1);
    localparam int DST = level_base(WIDTH, k);
    for (genvar g = 0; g < NG; g++) begin : g_node
      if ((k % 2) == 1) begin : g_inv
        cmpt_merge_inv u_m (
          .hi_big (nd_big[SRC+2*g+1]),
          .hi_eq  (nd_eq[SRC+2*g+1]),
          .lo_big (nd_big[SRC+2*g]),
          .lo_eq  (nd_eq[SRC+2*g]),
          .big_n  (nd_big[DST+g]),
          .eq_n   (nd_eq[DST+g])
        );
      end else begin : g_pos
        cmpt_merge_pos u_m (
          .hi_big_n (nd_big[SRC+2*g+1]),
          .hi_eq_n  (nd_eq[SRC+2*g+1]),
          .lo_big_n (nd_big[SRC+2*g]),
          .lo_eq_n  (nd_eq[SRC+2*g]),
          .big      (nd_big[DST+g]),
          .same     (nd_eq[DST+g])
        );
      end
    end
  end

  // root of the tree, named for the checks
  logic root_big;
  logic root_eq;
  assign root_big = nd_big[NODES-1];
  assign root_eq  = nd_eq[NODES-1];

  if (FLIP) begin : g_fix
    assign lt_o = ~root_big;
    assign eq_o = ~root_eq;
  end else begin : g_direct
    assign lt_o = root_big;
    assign eq_o = root_eq;
  end

  assign gt_o = ~(lt_o | eq_o);

  always_comb begin : chk
    // R4
    onehot_out_chk: assert ($onehot({lt_o, eq_o, gt_o}))
      else $error("outputs not one-hot");
    // R2
    eq_match_chk: assert (eq_o == (opa == opb))
      else $error("equal output disagrees with operands");
    // R1
    lt_match_chk: assert (lt_o == (opa < opb))
      else $error("less output disagrees with operands");
  end
endmodule

// File: tb/mag_cmp_tree_test.sv
module mag_cmp_tree_test;
  localparam int W = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  logic [W-1:0] a64 = '0, b64 = '0;
  logic         lt64, eq64, gt64;
  logic [7:0]   a8 = '0, b8 = '0;
  logic         lt8, eq8, gt8;
  logic [1:0]   a2 = '0, b2 = '0;
  logic         lt2, eq2, gt2;

  mag_cmp_tree #(.WIDTH(W)) uut (.opa(a64), .opb(b64), .lt_o(lt64), .eq_o(eq64), .gt_o(gt64));
  mag_cmp_tree #(.WIDTH(8)) uut_w8 (.opa(a8), .opb(b8), .lt_o(lt8), .eq_o(eq8), .gt_o(gt8));
  mag_cmp_tree #(.WIDTH(2)) uut_w2 (.opa(a2), .opb(b2), .lt_o(lt2), .eq_o(eq2), .gt_o(gt2));

  task automatic judge(input string tag, input logic l, input logic e, input logic g,
                       input logic xl, input logic xe, input logic xg);
    nvec++;
    if ({l, e, g} !== {xl, xe, xg}) begin
      nfail++;
      $display("FAIL %s: lt/eq/gt=%b%b%b expected %b%b%b", tag, l, e, g, xl, xe, xg);
    end else if (!$onehot({l, e, g})) begin
      nfail++;
      $display("FAIL R4 %s: lt/eq/gt=%b%b%b expected one-hot", tag, l, e, g);
    end
  endtask

  // behavioural reference: plain relational operators
  task automatic run64(input string tag, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    a64 = x; b64 = y;
    @(negedge clk);
    judge(tag, lt64, eq64, gt64, x < y, x == y, x > y);
  endtask

  task automatic run8(input string tag, input logic [7:0] x, input logic [7:0] y);
    @(posedge clk);
    a8 = x; b8 = y;
    @(negedge clk);
    judge(tag, lt8, eq8, gt8, x < y, x == y, x > y);
  endtask

  task automatic run2(input string tag, input logic [1:0] x, input logic [1:0] y);
    @(posedge clk);
    a2 = x; b2 = y;
    @(negedge clk);
    judge(tag, lt2, eq2, gt2, x < y, x == y, x > y);
  endtask

  initial begin
    logic [W-1:0] r;
    @(negedge clk);
    judge("R2 initial zeros", lt64, eq64, gt64, 1'b0, 1'b1, 1'b0);

    // R2 equal operands
    run64("R2 equal", 64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef);
    run64("R2 equal ones", '1, '1);
    // R5 MSB-only differences
    run64("R5 msb a", 64'h8000_0000_0000_0000, 64'h0);
    run64("R5 msb b", 64'h1234_5678_9abc_def0, 64'h9234_5678_9abc_def0);
    // R6 LSB-only differences
    run64("R6 lsb a", 64'h5555_aaaa_5555_aaab, 64'h5555_aaaa_5555_aaaa);
    run64("R6 lsb b", 64'hffff_ffff_ffff_fffe, '1);
    // R7 extremes
    run64("R7 zeros vs ones", '0, '1);
    run64("R7 ones vs zeros", '1, '0);

    // R1 R3 random pairs
    for (int n = 0; n < 3000; n++)
      run64("R1/R3 random", {$urandom, $urandom}, {$urandom, $urandom});

    // R8 highest differing bit decides, noise below it
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [W-1:0] x, y, noise;
      k = int'($urandom_range(W - 1, 0));
      x = {$urandom, $urandom};
      noise = {$urandom, $urandom};
      y = x;
      y[k] = ~x[k];
      for (int i = 0; i < k; i++) y[i] = noise[i];
      run64("R8 top diff bit", x, y);
    end

    // R9 exhaustive at 8 bits (even merge count) and 2 bits (leaf only)
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        run8("R9 width 8", 8'(x), 8'(y));
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++)
        run2("R9 width 2", 2'(x), 2'(y));

    r = {$urandom, $urandom};
    run64("R2 equal random", r, r);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule